// File: doc/BRIEF.md
# Two-Stage Port Range Matcher

This block decides, for every rule in a small rule table, whether a 16-bit transport port lies inside that rule's inclusive range. Each rule holds a lower bound and an upper bound. The block splits the comparison into two pipelined 8-bit strides. The first stride compares the port's upper byte with the upper bytes of both bounds and stores a relation code for each rule. The second stride uses that code and the port's lower byte to produce the final verdict for each rule.

A classifier puts one port on the input each clock with a valid strobe. Two cycles later it receives an N-bit vector with one bit per rule. Rule bounds are loaded one rule at a time through a write port. Choosing among several matching rules is left to the logic downstream.

Top module: `port_range_match`

## Requirements
- R1: A bound write (`cfgWe` high, rule `cfgIdx`, bounds `cfgLo`/`cfgHi`) applies to every port presented on the clock after the write.
- R2: Bit i of `matchVec` is 1 exactly when `cfgLo[i] <= port <= cfgHi[i]`, with both ends inclusive. Each rule is evaluated independently.
- R3: When the port's upper byte lies strictly between the two bounds' upper bytes, the rule matches whatever the lower byte is. When the upper byte is below the lower bound's upper byte, or above the upper bound's upper byte, the rule never matches.
- R4: When the port's upper byte equals only the lower bound's upper byte, a match needs lower byte >= the lower bound's lower byte. When it equals only the upper bound's upper byte, a match needs lower byte <= the upper bound's lower byte. When it equals both, a match needs both conditions.
- R5: A rule whose lower bound exceeds its upper bound matches no port.
- R6: A rule with bounds 0x0000 and 0xFFFF matches every port.
- R7: `matchValid` rises two clocks after the input clock in which `inValid` was high. It stays high for one cycle for each valid input. One port is accepted every clock, and clocks with `inValid` low produce no `matchValid`.
- R8: After reset, `matchValid` and `matchVec` are 0.
- R9: After reset, every rule holds bounds 0x0000/0x0000 and so matches only port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Port value on `inPort` is valid this cycle |
| inPort | input | 16 | Port to classify |
| cfgWe | input | 1 | Write strobe for one rule's bounds |
| cfgIdx | input | log2(NUM_RULES) | Rule index to write |
| cfgLo | input | 16 | Inclusive lower bound |
| cfgHi | input | 16 | Inclusive upper bound |
| matchValid | output | 1 | `matchVec` holds the result for a port |
| matchVec | output | NUM_RULES | Per-rule in-range result |

## Verification
The bench aims at ports that sit exactly on a bound, and at ports one step outside a bound. It also covers ports whose upper byte equals one bound, the other bound, or both at once. A stage 1 that mixed up `>=` with `>`, or that applied only one low-byte test in the equal-both case, would give the wrong bit on those edges. Inverted rules whose upper bytes are inverted by a single step are included, because a relation code that ignores the opposite bound would let them match. Back-to-back streaming checks the results against the correct input order and cycle: a broken valid pipeline would shift or drop vectors.

// File: rtl/port_range_pkg.sv
package port_range_pkg;

  // Upper-byte relation of a port to one rule, produced by stage 0.
  typedef enum logic [2:0] {
    REL_OUT     = 3'd0,
    REL_INSIDE  = 3'd1,
    REL_EQ_LO   = 3'd2,
    REL_EQ_HI   = 3'd3,
    REL_EQ_BOTH = 3'd4
  } relCode_e;

  typedef struct packed {
    logic s0Load;
    logic s1Load;
    logic cfgLoad;
  } pipeStrobe_t;

endpackage

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import port_range_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        cfgWe,
  output pipeStrobe_t strobe,
  output logic        matchValid
);

  logic s0Valid;
  logic s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s0Valid <= 1'b0;
      s1Valid <= 1'b0;
    end else begin
      s0Valid <= inValid;
      s1Valid <= s0Valid;
    end
  end

  always_comb begin
    strobe.s0Load  = inValid;
    strobe.s1Load  = s0Valid;
    strobe.cfgLoad = cfgWe;
  end

  assign matchValid = s1Valid;

  // R7: a valid input shows up two clocks later
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 matchValid);

  // R7: no result without a valid input two clocks earlier
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> $past(strobe.s1Load));

endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import port_range_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int STRIDE_W  = 8,
  localparam int PORT_W   = 2 * STRIDE_W,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pipeStrobe_t          strobe,
  input  logic [PORT_W-1:0]    inPort,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic [PORT_W-1:0]    cfgLo,
  input  logic [PORT_W-1:0]    cfgHi,
  output logic [NUM_RULES-1:0] matchVec
);

  logic [PORT_W-1:0]   loBound [NUM_RULES];
  logic [PORT_W-1:0]   hiBound [NUM_RULES];
  relCode_e            relNext [NUM_RULES];
  relCode_e            relQ    [NUM_RULES];
  logic [STRIDE_W-1:0] portLoQ;
  logic [NUM_RULES-1:0] matchNext;

  // Rule table
  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_RULES; r++) begin
      if (!rstN) begin
        loBound[r] <= '0;
        hiBound[r] <= '0;
      end else if (strobe.cfgLoad && cfgIdx == IDX_W'(r)) begin
        loBound[r] <= cfgLo;
        hiBound[r] <= cfgHi;
      end
    end
  end

  // Stage 0: upper-byte relation per rule
  always_comb begin
    for (int r = 0; r < NUM_RULES; r++) begin
      logic [STRIDE_W-1:0] ph, lh, uh;
      ph = inPort[PORT_W-1:STRIDE_W];
      lh = loBound[r][PORT_W-1:STRIDE_W];
      uh = hiBound[r][PORT_W-1:STRIDE_W];
      if (ph == lh && ph == uh)     relNext[r] = REL_EQ_BOTH;
      else if (ph == lh && ph < uh) relNext[r] = REL_EQ_LO;
      else if (ph == uh && ph > lh) relNext[r] = REL_EQ_HI;
      else if (ph > lh && ph < uh)  relNext[r] = REL_INSIDE;
      else                          relNext[r] = REL_OUT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portLoQ <= '0;
      for (int r = 0; r < NUM_RULES; r++) relQ[r] <= REL_OUT;
    end else if (strobe.s0Load) begin
      portLoQ <= inPort[STRIDE_W-1:0];
      for (int r = 0; r < NUM_RULES; r++) relQ[r] <= relNext[r];
    end
  end

  // Stage 1: low-byte decision qualified by the stage-0 code
  always_comb begin
    for (int r = 0; r < NUM_RULES; r++) begin
      logic geLo, leHi;
      geLo = portLoQ >= loBound[r][STRIDE_W-1:0];
      leHi = portLoQ <= hiBound[r][STRIDE_W-1:0];
      unique case (relQ[r])
        REL_INSIDE:  matchNext[r] = 1'b1;
        REL_EQ_LO:   matchNext[r] = geLo;
        REL_EQ_HI:   matchNext[r] = leHi;
        REL_EQ_BOTH: matchNext[r] = geLo && leHi;
        default:     matchNext[r] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              matchVec <= '0;
    else if (strobe.s1Load) matchVec <= matchNext;
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_chk
    // R3: outside code never produces a match
    a_r3_outside_never: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.s1Load && relQ[g] == REL_OUT) |=> !matchVec[g]);
    // R3: strictly-inside code always produces a match
    a_r3_inside_always: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.s1Load && relQ[g] == REL_INSIDE) |=> matchVec[g]);
    // R6: a stable full-range rule always matches
    a_r6_full_range: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.s1Load && loBound[g] == '0 && hiBound[g] == '1 &&
       $stable(loBound[g]) && $stable(hiBound[g])) |=> matchVec[g]);
    // R5: a stable inverted rule never matches
    a_r5_inverted_none: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.s1Load && loBound[g] > hiBound[g] &&
       $stable(loBound[g]) && $stable(hiBound[g])) |=> !matchVec[g]);
  end

endmodule

// File: rtl/port_range_match.sv
module port_range_match
  import port_range_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int STRIDE_W  = 8,
  localparam int PORT_W   = 2 * STRIDE_W,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [PORT_W-1:0]    inPort,
  input  logic                 cfgWe,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic [PORT_W-1:0]    cfgLo,
  input  logic [PORT_W-1:0]    cfgHi,
  output logic                 matchValid,
  output logic [NUM_RULES-1:0] matchVec
);

  pipeStrobe_t strobe;

  prc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .cfgWe      (cfgWe),
    .strobe     (strobe),
    .matchValid (matchValid)
  );

  prc_datapath #(
    .NUM_RULES (NUM_RULES),
    .STRIDE_W  (STRIDE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inPort   (inPort),
    .cfgIdx   (cfgIdx),
    .cfgLo    (cfgLo),
    .cfgHi    (cfgHi),
    .matchVec (matchVec)
  );

endmodule

// File: tb/port_range_match_bench.sv
module port_range_match_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] inPort;
  logic        cfgWe;
  logic [1:0]  cfgIdx;
  logic [15:0] cfgLo, cfgHi;
  logic        matchValid;
  logic [3:0]  matchVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_range_match u_port_range_match (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPort(inPort),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgLo(cfgLo), .cfgHi(cfgHi),
    .matchValid(matchValid), .matchVec(matchVec)
  );

  // {port, expected vector bits rule3..rule0}
  // rules: 0=[0000,FFFF] 1=[1234,1256] 2=[10F0,2010] 3=[3000,3000]
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {16'h0000, 4'b0001}, {16'h1233, 4'b0101}, {16'h1234, 4'b0111},
    {16'h1256, 4'b0111}, {16'h1257, 4'b0101}, {16'h10EF, 4'b0001},
    {16'h10F0, 4'b0101}, {16'h2010, 4'b0101}, {16'h2011, 4'b0001},
    {16'h1F00, 4'b0101}, {16'h3000, 4'b1001}, {16'h3001, 4'b0001},
    {16'hFFFF, 4'b0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeRule(input logic [1:0] idx, input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgLo = lo; cfgHi = hi;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic applyOne(input logic [15:0] p, input logic [3:0] exp, input string req);
    @(negedge clk);
    inValid = 1'b1; inPort = p;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, 32'(matchValid), 32'd1);
    check({req, " vector"}, 32'(matchVec), 32'(exp));
    @(negedge clk);
    check({req, " single pulse"}, 32'(matchValid), 32'd0);
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inPort = '0;
    cfgWe = 1'b0; cfgIdx = '0; cfgLo = '0; cfgHi = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", 32'(matchValid), 32'd0);
    check("R8 reset vector", 32'(matchVec), 32'd0);
    rstN = 1'b1;

    // R9: reset bounds 0/0 match port 0 only
    applyOne(16'h0000, 4'b1111, "R9 port0");
    applyOne(16'h0001, 4'b0000, "R9 port1");

    // R1: writes take effect on the next clock
    writeRule(2'd0, 16'h0000, 16'hFFFF);
    writeRule(2'd1, 16'h1234, 16'h1256);
    writeRule(2'd2, 16'h10F0, 16'h2010);
    writeRule(2'd3, 16'h3000, 16'h3000);
    applyOne(16'h3000, 4'b1001, "R1 after write");

    // R2 R3 R4 R6 R7: back-to-back stream from the table
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R7 stream valid", 32'(matchValid), 32'd1);
        check($sformatf("R2 R4 stream port %h", VEC[i-2][19:4]),
              32'(matchVec), 32'(VEC[i-2][3:0]));
      end
      if (i < NV) begin
        inValid = 1'b1; inPort = VEC[i][19:4];
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 idle no valid", 32'(matchValid), 32'd0);

    // R4: upper byte equal to only one bound
    applyOne(16'h10F1, 4'b0101, "R4 eq lo above");
    applyOne(16'h200F, 4'b0101, "R4 eq hi below");

    // R5: inverted ranges
    writeRule(2'd1, 16'h0205, 16'h01FF);
    writeRule(2'd2, 16'h0105, 16'h0102);
    applyOne(16'h0200, 4'b0001, "R5 inverted hi bytes");
    applyOne(16'h01FF, 4'b0001, "R5 inverted at hi");
    applyOne(16'h0103, 4'b0001, "R5 inverted same hi byte");

    // R3: upper byte strictly inside with extreme low bytes
    writeRule(2'd3, 16'h40FF, 16'h4200);
    applyOne(16'h4100, 4'b1001, "R3 inside low 00");
    applyOne(16'h41FF, 4'b1001, "R3 inside low FF");
    applyOne(16'h4300, 4'b0001, "R3 above");

    // R6: full range at the extremes
    applyOne(16'hFFFF, 4'b0001, "R6 full max");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule